// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a registered synchronous SRAM. The memory is word-organised, with four nine-bit byte lanes per 36-bit word. Accesses begin with one of two active-low address strobes. The processor-side strobe starts a read, and the controller-side strobe starts either a read or a write. A two-bit burst counter then walks the low address bits on later clocks while the advance input is held low.

Three chip enables decide whether an access takes place, but they are looked at only on the clock that loads a new address. Write lanes come from a global-write override, or from per-lane selects gated by a byte-write enable. Read data is registered. The data output carries a drive flag that follows an asynchronous active-low output enable, and that flag is held off for the first read clock after the part leaves the deselected state.

The register array decodes only the low `MEM_AW` address bits, so each address aliases onto word `addr % 2**MEM_AW`. The full address is still captured and used for the burst arithmetic.

Top module: `sbs_core`

## Requirements
- R1: While reset is asserted and after it is released, `dout_drive` is 0 until a read has been performed, and the part starts out deselected.
- R2: A new address is loaded on a clock where `strobe_ctl_n` is 0, or where `strobe_cpu_n` and `sel1_n` are both 0. The part is selected when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at that clock. On clocks with no load, the select pins are ignored and the previous selection is kept. A deselected part neither writes nor drives data.
- R3: When `sel1_n` is 1, a low `strobe_cpu_n` does not load anything. If the part is still selected, that clock is treated as a burst continuation at the held address.
- R4: When both strobes are low and `sel1_n` is 0, the clock is a read of the new address. All write enables are ignored on that clock.
- R5: On a continuation clock, `adv_n`=0 increments the two low address bits before the access, wrapping from 3 to 0, and the upper bits stay unchanged. With `adv_n`=1, the access repeats the current address.
- R6: When `all_wr_n` is 0, a write stores all four lanes, whatever the values of `byte_wr_en_n` and `lane_wr_n`.
- R7: When `all_wr_n` is 1, lane k (data bits 9k+8 down to 9k) is written only if `byte_wr_en_n` is 0 and `lane_wr_n[k]` is 0. A clock that enables no lane is a read.
- R8: A write through `strobe_ctl_n` stores `din` at the loaded address on that same clock. A continuation write stores it at the burst address.
- R9: Read data appears on `dout` after the clock edge of the read. `dout_drive` is 1 only when the last clock was a read and `out_en_n` is 0, and it follows `out_en_n` with no clock. Write clocks leave `dout_drive` at 0.
- R10: On the first read clock after the deselected state, `dout_drive` stays 0 even with `out_en_n` low. `dout` still carries the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte write gate, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Registered read data |
| dout_drive | output | 1 | Output driver enable |

## Verification
The hardest state to reach is a deselected part that then receives clocks that look like writes and bursts, while its select pins go back to active without any strobe. The bench loads an address with `sel2` low, then applies such clocks with junk data, and reads the address back afterwards. That follow-up read is also the first read after deselection, so one sequence checks both the held selection and the suppressed drive flag. The burst wrap is reached by loading an address whose low bits are 2 and advancing three times. A word just past the naive increment is preloaded, which exposes any carry into the upper bits.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Active-high lane write mask from the active-low controls.
  function automatic logic [LANES-1:0] write_lanes(
      input logic             gw_n,
      input logic             bwe_n,
      input logic [LANES-1:0] bw_n);
    logic [LANES-1:0] m;
    if (!gw_n)      m = '1;
    else if (bwe_n) m = '0;
    else            m = ~bw_n;
    return m;
  endfunction

  // Two-bit linear burst step, wrapping 3 -> 0.
  function automatic logic [1:0] burst_step(input logic [1:0] c);
    return c + 2'd1;
  endfunction

  // Replace the enabled lanes of a word.
  function automatic logic [WORD_W-1:0] merge_lanes(
      input logic [WORD_W-1:0] old_w,
      input logic [WORD_W-1:0] new_w,
      input logic [LANES-1:0]  en);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (en[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/sbs_select.sv
`timescale 1ns/1ps
module sbs_select #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  output logic              load_o,
  output logic              cpu_load_o,
  output logic              cont_o,
  output logic              access_o,
  output logic              sel_held_o,
  output logic [ADDR_W-3:0] base_hi_o
);
  logic              chip_on;
  logic              sel_q;
  logic [ADDR_W-3:0] base_hi_q;

  // The processor strobe counts only while sel1_n is low.
  assign cpu_load_o = ~strobe_cpu_n & ~sel1_n;
  assign load_o     = cpu_load_o | ~strobe_ctl_n;
  assign chip_on    = ~sel1_n & sel2 & ~sel3_n;
  assign cont_o     = ~load_o & sel_q;
  assign access_o   = load_o ? chip_on : sel_q;
  assign sel_held_o = sel_q;
  assign base_hi_o  = base_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      base_hi_q <= '0;
    end else if (load_o) begin
      sel_q     <= chip_on;
      base_hi_q <= addr[ADDR_W-1:2];
    end
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] load_bits,
  input  logic       step,
  output logic [1:0] cnt_cur
);
  logic [1:0] cnt_q;

  // Value used by the access on this clock: stepped before use.
  assign cnt_cur = step ? burst_step(cnt_q) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= 2'd0;
    else if (load) cnt_q <= load_bits;
    else           cnt_q <= cnt_cur;
  end
endmodule

// File: rtl/sbs_lane_decode.sv
`timescale 1ns/1ps
module sbs_lane_decode
  import sbs_pkg::*;
(
  input  logic             all_wr_n,
  input  logic             byte_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             access,
  input  logic             load,
  input  logic             cpu_load,
  output logic [LANES-1:0] lanes_o,
  output logic             wr_o,
  output logic             rd_o
);
  logic write_allowed;

  assign lanes_o       = write_lanes(all_wr_n, byte_wr_en_n, lane_wr_n);
  // A processor-strobe load is always a read.
  assign write_allowed = load ? ~cpu_load : 1'b1;
  assign wr_o          = access & write_allowed & (|lanes_o);
  assign rd_o          = access & ~wr_o;
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lanes,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              sel_held,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] rd_data,
  output logic              dout_drive
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] idx;
  logic [WORD_W-1:0] rd_q;
  logic              rd_valid_q;
  logic              mask_q;

  assign idx = MEM_AW'(acc_addr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= merge_lanes(mem[idx], din, lanes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
      mask_q     <= 1'b0;
    end else begin
      if (rd_en) rd_q <= mem[idx];
      rd_valid_q <= rd_en;
      // The first read out of the deselected state keeps the driver off.
      mask_q     <= rd_en & ~sel_held;
    end
  end

  assign rd_data    = rd_q;
  assign dout_drive = rd_valid_q & ~mask_q & ~out_en_n;
endmodule

// File: rtl/sbs_core.sv
`timescale 1ns/1ps
module sbs_core
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              all_wr_n,
  input  logic              byte_wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_drive
);
  logic              ev_load;
  logic              ev_cpu_load;
  logic              ev_cont;
  logic              ev_access;
  logic              ev_wr;
  logic              ev_rd;
  logic              sel_held;
  logic [ADDR_W-3:0] base_hi;
  logic [1:0]        cnt_cur;
  logic [LANES-1:0]  lanes;
  logic [ADDR_W-1:0] acc_addr;

  sbs_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .load_o(ev_load), .cpu_load_o(ev_cpu_load), .cont_o(ev_cont),
    .access_o(ev_access), .sel_held_o(sel_held), .base_hi_o(base_hi)
  );

  sbs_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .load_bits(addr[1:0]),
    .step(ev_cont & ~adv_n), .cnt_cur(cnt_cur)
  );

  assign acc_addr = ev_load ? addr : {base_hi, cnt_cur};

  sbs_lane_decode u_dec (
    .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n),
    .access(ev_access), .load(ev_load), .cpu_load(ev_cpu_load),
    .lanes_o(lanes), .wr_o(ev_wr), .rd_o(ev_rd)
  );

  sbs_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_wr), .rd_en(ev_rd), .lanes(lanes),
    .acc_addr(acc_addr), .sel_held(sel_held), .out_en_n(out_en_n),
    .din(din), .rd_data(dout), .dout_drive(dout_drive)
  );
endmodule

// File: rtl/sbs_core_chk.sv
`timescale 1ns/1ps
module sbs_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_cpu_n,
  input logic       strobe_ctl_n,
  input logic       sel1_n,
  input logic       adv_n,
  input logic       all_wr_n,
  input logic       out_en_n,
  input logic       dout_drive,
  input logic       ev_load,
  input logic       ev_cpu_load,
  input logic       ev_cont,
  input logic       ev_wr,
  input logic       ev_rd,
  input logic       sel_held,
  input logic [1:0] cnt_cur,
  input logic [3:0] lanes
);
  a_r2_selection_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load |=> $stable(sel_held));

  a_r3_cpu_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && sel1_n && strobe_ctl_n) |=> $stable(sel_held));

  a_r4_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cpu_load |-> !ev_wr);

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cont && cnt_cur == 2'd3) ##1 (ev_cont && !adv_n) |-> cnt_cur == 2'd0);

  a_r5_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cont ##1 (ev_cont && adv_n) |-> cnt_cur == $past(cnt_cur));

  a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && !all_wr_n) |-> lanes == 4'hF);

  a_r9_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_drive |-> !out_en_n);

  a_r9_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !dout_drive);

  a_r10_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && !sel_held) |=> !dout_drive);
endmodule

bind sbs_core sbs_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_cpu_n(strobe_cpu_n),
  .strobe_ctl_n(strobe_ctl_n), .sel1_n(sel1_n), .adv_n(adv_n),
  .all_wr_n(all_wr_n), .out_en_n(out_en_n), .dout_drive(dout_drive),
  .ev_load(ev_load), .ev_cpu_load(ev_cpu_load), .ev_cont(ev_cont),
  .ev_wr(ev_wr), .ev_rd(ev_rd), .sel_held(sel_held),
  .cnt_cur(cnt_cur), .lanes(lanes)
);

// File: tb/tb_sbs_core.sv
`timescale 1ns/1ps
module tb_sbs_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] addr;
  logic        strobe_cpu_n, strobe_ctl_n, adv_n;
  logic        sel1_n, sel2, sel3_n;
  logic        all_wr_n, byte_wr_en_n;
  logic [3:0]  lane_wr_n;
  logic        out_en_n;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_drive;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  logic [35:0] shadow [64];

  sbs_core dut (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    addr = '0; strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
    all_wr_n = 1; byte_wr_en_n = 1; lane_wr_n = 4'hF; din = '0;
  endtask

  function automatic logic [3:0] model_lanes(input logic gw, input logic bwe,
                                             input logic [3:0] bw);
    if (gw == 1'b0) return 4'hF;
    if (bwe == 1'b1) return 4'h0;
    return ~bw;
  endfunction

  task automatic model_write(input logic [16:0] a, input logic [35:0] d,
                             input logic [3:0] en);
    for (int k = 0; k < 4; k++)
      if (en[k]) shadow[a[5:0]][9*k +: 9] = d[9*k +: 9];
  endtask

  // Write load via the controller strobe.
  task automatic wr_load(input logic [16:0] a, input logic [35:0] d,
                         input logic gw, input logic bwe, input logic [3:0] bw);
    addr = a; din = d; strobe_ctl_n = 0;
    all_wr_n = gw; byte_wr_en_n = bwe; lane_wr_n = bw;
    tick();
    model_write(a, d, model_lanes(gw, bwe, bw));
    idle();
  endtask

  task automatic rd_load(input logic [16:0] a, output logic [35:0] q);
    addr = a; strobe_cpu_n = 0;
    tick();
    q = dout;
    idle();
  endtask

  task automatic t_reset();
    check(dout_drive == 1'b0, "R1 drive off after reset", {35'd0, dout_drive}, 36'd0);
  endtask

  task automatic t_global_write();
    logic [35:0] q;
    wr_load(17'h00101, 36'hA_BCDE_F012, 1'b0, 1'b1, 4'hF);
    check(dout_drive == 1'b0, "R9 write clock not driven", {35'd0, dout_drive}, 36'd0);
    rd_load(17'h00101, q);
    check(q == 36'hA_BCDE_F012, "R6 global write all lanes", q, 36'hA_BCDE_F012);
    check(dout_drive == 1'b1, "R9 read drives", {35'd0, dout_drive}, 36'd1);
    out_en_n = 1; #1;
    check(dout_drive == 1'b0, "R9 async oe off", {35'd0, dout_drive}, 36'd0);
    out_en_n = 0; #1;
    check(dout_drive == 1'b1, "R9 async oe on", {35'd0, dout_drive}, 36'd1);
  endtask

  task automatic t_byte_write();
    logic [35:0] q;
    wr_load(17'h00101, 36'h5_5555_5555, 1'b1, 1'b0, 4'b1010);
    rd_load(17'h00101, q);
    check(q == shadow[6'h01], "R7 lanes 0 and 2 only", q, shadow[6'h01]);
    wr_load(17'h00101, 36'h0_0000_0000, 1'b1, 1'b1, 4'h0);
    rd_load(17'h00101, q);
    check(q == shadow[6'h01], "R7 byte gate high no write", q, shadow[6'h01]);
  endtask

  task automatic t_burst();
    logic [35:0] q;
    logic [16:0] a = 17'h12346;
    wr_load(17'h12348, 36'h7_7777_7777, 1'b0, 1'b1, 4'hF);
    wr_load(a, 36'h1_0000_0001, 1'b0, 1'b1, 4'hF);
    for (int i = 1; i < 4; i++) begin
      adv_n = 0; all_wr_n = 0; din = 36'h1_0000_0001 + 36'(i);
      tick();
      model_write({a[16:2], 2'(a[1:0] + 2'(i))}, din, 4'hF);
    end
    idle(); tick();
    for (int c = 0; c < 4; c++) begin
      rd_load({a[16:2], 2'(c)}, q);
      check(q == shadow[{a[5:2], 2'(c)}], "R8 R5 burst write lane", q,
            shadow[{a[5:2], 2'(c)}]);
    end
    rd_load(17'h12348, q);
    check(q == 36'h7_7777_7777, "R5 no carry into upper bits", q, 36'h7_7777_7777);
    // burst read from cnt 2: 2,3,0, hold 0, 1
    addr = a; strobe_cpu_n = 0; tick(); idle();
    check(dout == shadow[6'h06], "R9 burst read first", dout, shadow[6'h06]);
    adv_n = 0; tick();
    check(dout == shadow[6'h07], "R5 step to 3", dout, shadow[6'h07]);
    tick();
    check(dout == shadow[6'h04], "R5 wrap to 0", dout, shadow[6'h04]);
    adv_n = 1; tick();
    check(dout == shadow[6'h04], "R5 hold when adv high", dout, shadow[6'h04]);
    adv_n = 0; tick(); adv_n = 1;
    check(dout == shadow[6'h05], "R5 step to 1", dout, shadow[6'h05]);
    // processor strobe with sel1_n high: continuation at cnt 1
    addr = 17'h00101; strobe_cpu_n = 0; sel1_n = 1; tick(); idle();
    check(dout == shadow[6'h05], "R3 cpu strobe ignored", dout, shadow[6'h05]);
  endtask

  task automatic t_priority();
    logic [35:0] q;
    addr = 17'h00101; strobe_cpu_n = 0; strobe_ctl_n = 0;
    all_wr_n = 0; din = 36'hF_FFFF_FFFF;
    tick(); idle();
    check(dout == shadow[6'h01], "R4 both strobes read", dout, shadow[6'h01]);
    rd_load(17'h00101, q);
    check(q == shadow[6'h01], "R4 no write on priority", q, shadow[6'h01]);
  endtask

  task automatic t_deselect();
    logic [35:0] q;
    addr = 17'h00120; strobe_ctl_n = 0; sel2 = 0; all_wr_n = 0;
    din = 36'hD_EADD_EADD;
    tick(); idle();
    check(dout_drive == 1'b0, "R2 deselected no drive", {35'd0, dout_drive}, 36'd0);
    for (int i = 0; i < 3; i++) begin
      all_wr_n = 0; din = 36'hB_ADBA_DBAD; tick();
      check(dout_drive == 1'b0, "R2 selects ignored without load",
            {35'd0, dout_drive}, 36'd0);
    end
    idle();
    rd_load(17'h00120, q);
    check(q == shadow[6'h20], "R2 no write while deselected", q, shadow[6'h20]);
    check(dout_drive == 1'b0, "R10 first read masked", {35'd0, dout_drive}, 36'd0);
    tick();
    check(dout_drive == 1'b1, "R10 second read drives", {35'd0, dout_drive}, 36'd1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    idle(); out_en_n = 0; rst_n = 0;
    repeat (3) tick();
    check(dout_drive == 1'b0, "R1 drive off in reset", {35'd0, dout_drive}, 36'd0);
    rst_n = 1; tick();
    // preset the words later read so the shadow matches
    wr_load(17'h00120, 36'h3_1415_9265, 1'b0, 1'b1, 4'hF);
    t_reset();
    t_global_write();
    t_byte_write();
    t_burst();
    t_priority();
    t_deselect();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule